// File: doc/BRIEF.md
# Shared-Period Multi-Channel Pulse Width Modulator

This block drives up to four pulse outputs from a single time base. One 8-bit prescaler divides the input clock into local ticks. A free-running 8-bit counter steps once per tick, so every output period is exactly 256 ticks long. Each channel compares that shared counter with its own 8-bit duty value. All channels therefore run at the same frequency and start each period on the same clock cycle. Only their pulse widths differ.

Software programs the block through a word-addressed register port. The address is a byte offset and writes take effect on the clock edge. Each channel has a duty register. A control register holds the prescaler, split into two nibbles, together with one run bit that starts or stops every channel at once. A separate interrupt-enable bit is stored and can be read back.

A new duty value sits in a holding register. It reaches the comparator only when the counter wraps from 255 to 0, so a period is never cut short or stretched by a write.

Top module: `pwm_shared`

## Requirements
- R1: After reset every output is low, and the duty, control and interrupt-enable registers all read 0.
- R2: The duty register of channel n sits at byte offset 4*n and holds bits [7:0]. Bits [31:8] read back as 0.
- R3: The control register sits at offset 0x50. Prescaler bits [3:0] map to control bits [3:0], prescaler bits [7:4] map to control bits [14:11], and the run bit is bit 9. All other bits read 0, so an all-ones write reads back as 0x7A0F.
- R4: The interrupt-enable register sits at offset 0x54 and stores bit 0 only.
- R5: While the run bit is 0, all outputs are low and the tick and period counters are held at zero. Setting the run bit starts a fresh period from counter value 0.
- R6: One output period lasts 256*(P+1) clock cycles, where P is the prescaler value, and every period begins with the output high.
- R7: A duty value D keeps the output high for (D+1)*(P+1) clock cycles at the start of each period and low for the rest. A duty of 0 therefore gives a pulse of one tick.
- R8: A duty value of 255 keeps the output high for the whole period, so it never goes low while running.
- R9: A duty write made while running does not change the current period. It applies from the next counter wrap.
- R10: All channels share one counter, so every running channel rises in the same clock cycle.
- R11: Writes to a duty offset at or beyond NUM_CH channels are ignored, and such offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Register byte offset used for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, driven combinationally |
| pwm_o | output | NUM_CH | One pulse output per channel |

## Verification
Bad internal state shows up at the outputs within one period. A counter that skips, holds or fails to restart changes both the measured high time and the position of the next rising edge. A holding register that passes a value through too early changes the high count of the period in which the write landed. Comparing channels within one period exposes any phase split between them. Running the prescaler at a value whose two nibbles are both non-zero checks that the split field is decoded correctly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int REG_W       = 32;
    localparam int DUTY_W      = 8;
    localparam int DIV_W       = 8;
    localparam int CNT_W       = 8;
    localparam int MAX_CH      = 4;

    localparam int CTRL_OFS    = 'h50;
    localparam int IRQEN_OFS   = 'h54;
    localparam int DUTY_STRIDE = 4;

    localparam int RUN_BIT     = 9;
    localparam int DIV_LO_LSB  = 0;
    localparam int DIV_HI_LSB  = 11;
    localparam int NIB_W       = DIV_W / 2;

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
    } tb_cfg_t;

    function automatic tb_cfg_t ctrl_unpack(input logic [REG_W-1:0] word);
        tb_cfg_t c;
        c.run = word[RUN_BIT];
        c.div = {word[DIV_HI_LSB +: NIB_W], word[DIV_LO_LSB +: NIB_W]};
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input tb_cfg_t c);
        logic [REG_W-1:0] word;
        word = '0;
        word[DIV_LO_LSB +: NIB_W] = c.div[NIB_W-1:0];
        word[DIV_HI_LSB +: NIB_W] = c.div[DIV_W-1:NIB_W];
        word[RUN_BIT]             = c.run;
        return word;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [REG_W-1:0]               wdata,
    output logic [REG_W-1:0]               rdata,
    output tb_cfg_t                        cfg,
    output logic [NUM_CH-1:0][DUTY_W-1:0]  duty_next
);

    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] IRQEN_A = ADDR_W'(IRQEN_OFS);

    tb_cfg_t                       cfg_q;
    logic                          irq_en_q;
    logic [NUM_CH-1:0][DUTY_W-1:0] duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            irq_en_q <= 1'b0;
            duty_q   <= '0;
        end else if (wr_en) begin
            if (addr == CTRL_A)
                cfg_q <= ctrl_unpack(wdata);
            if (addr == IRQEN_A)
                irq_en_q <= wdata[0];
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(DUTY_STRIDE * i))
                    duty_q[i] <= wdata[DUTY_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A)
            rdata = ctrl_pack(cfg_q);
        if (addr == IRQEN_A)
            rdata = {{(REG_W-1){1'b0}}, irq_en_q};
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(DUTY_STRIDE * i))
                rdata = {{(REG_W-DUTY_W){1'b0}}, duty_q[i]};
        end
    end

    assign cfg       = cfg_q;
    assign duty_next = duty_q;

    AST_RUN_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_A) |=> (cfg.run == $past(wdata[RUN_BIT])));  // R3

    AST_IRQ_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == IRQEN_A) |=> (rdata[0] == $past(wdata[0]) || addr != IRQEN_A));  // R4

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int PS_W = DIV_W,
    parameter int C_W  = CNT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] div,
    output logic [C_W-1:0]  cnt,
    output logic            wrap
);

    logic [PS_W-1:0] pre_q;
    logic [C_W-1:0]  cnt_q;
    logic            tick;

    assign tick = run && (pre_q >= div);
    assign wrap = tick && (cnt_q == {C_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (cnt_q == C_W'($past(cnt_q) + 1'b1)));  // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt_q));  // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0 && pre_q == '0));  // R5

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int D_W = DUTY_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           wrap,
    input  logic [D_W-1:0] cnt,
    input  logic [D_W-1:0] duty_next,
    output logic           pwm_o
);

    logic [D_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (!run || wrap)
            active_q <= duty_next;
    end

    assign pwm_o = run && (cnt <= active_q);

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(active_q));  // R9

    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> (cnt == '0));  // R10

endmodule

// File: rtl/pwm_shared.sv
module pwm_shared
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    tb_cfg_t                       cfg;
    logic [NUM_CH-1:0][DUTY_W-1:0] duty_next;
    logic [CNT_W-1:0]              cnt;
    logic                          wrap;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .cfg       (cfg),
        .duty_next (duty_next)
    );

    pwm_timebase #(.PS_W(DIV_W), .C_W(CNT_W)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .run  (cfg.run),
        .div  (cfg.div),
        .cnt  (cnt),
        .wrap (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.D_W(DUTY_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (cfg.run),
            .wrap      (wrap),
            .cnt       (cnt),
            .duty_next (duty_next[g]),
            .pwm_o     (pwm_o[g])
        );
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !cfg.run |-> (pwm_o == '0));  // R5

endmodule

// File: tb/pwm_shared_test.sv
module pwm_shared_test;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [6:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [NCH-1:0] pwm_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_shared #(.NUM_CH(NCH), .ADDR_W(7)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    typedef struct packed {
        logic [7:0]  ps;
        logic [7:0]  duty;
        logic [15:0] hi;
        logic [15:0] per;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{8'd0,    8'd0,   16'd1,   16'd256},
        '{8'd0,    8'd100, 16'd101, 16'd256},
        '{8'd0,    8'd255, 16'd256, 16'd256},
        '{8'd2,    8'd9,   16'd30,  16'd768},
        '{8'h13,   8'd1,   16'd40,  16'd5120}
    };

    function automatic logic [31:0] ctl(input int ps, input bit en);
        return 32'((ps & 15) | ((ps >> 4) << 11) | (int'(en) << 9));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 7'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 7'(a);
        #1 d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int hi, hi2;
        int hc [NCH];
        bit last;

        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1 chk(pwm_o == '0, "R1 outputs", int'(pwm_o), 0);
        rd('h50, v); chk(v == 0, "R1 ctrl", int'(v), 0);
        rd('h00, v); chk(v == 0, "R1 duty0", int'(v), 0);
        rd('h54, v); chk(v == 0, "R1 irqen", int'(v), 0);

        // R2 duty register field
        wr('h08, 32'h1234_56AB);
        rd('h08, v); chk(v == 32'hAB, "R2 duty2 readback", int'(v), 'hAB);
        // R3 control field layout
        wr('h50, 32'hFFFF_FFFF);
        rd('h50, v); chk(v == 32'h7A0F, "R3 ctrl readback", int'(v), 'h7A0F);
        wr('h50, 32'h0);
        // R4 interrupt enable
        wr('h54, 32'hFFFF_FFFF);
        rd('h54, v); chk(v == 32'h1, "R4 irqen readback", int'(v), 1);
        // R11 offset past the last channel
        wr('h10, 32'h55);
        rd('h10, v); chk(v == 0, "R11 out-of-range duty", int'(v), 0);
        wr('h08, 32'h0);

        // R6 R7 R8 vector walk on channel 0
        for (int i = 0; i < NV; i++) begin
            wr('h50, ctl(VEC[i].ps, 1'b0));
            wr('h00, 32'(VEC[i].duty));
            wr('h50, ctl(VEC[i].ps, 1'b1));
            hi = 0; last = 1'b0;
            for (int k = 0; k < int'(VEC[i].per); k++) begin
                if (pwm_o[0]) hi++;
                last = pwm_o[0];
                @(negedge clk);
            end
            chk(hi == int'(VEC[i].hi), (VEC[i].duty == 255) ? "R8 high ticks" : "R7 high ticks",
                hi, int'(VEC[i].hi));
            chk(last == (VEC[i].duty == 255), "R8 last tick level", int'(last),
                int'(VEC[i].duty == 255));
            chk(pwm_o[0] == 1'b1, "R6 next period starts high", int'(pwm_o[0]), 1);
        end

        // R10 all channels in phase
        wr('h50, ctl(0, 1'b0));
        wr('h00, 32'd0); wr('h04, 32'd50); wr('h08, 32'd100); wr('h0C, 32'd255);
        wr('h50, ctl(0, 1'b1));
        chk(pwm_o == 4'hF, "R10 common rise", int'(pwm_o), 15);
        for (int c = 0; c < NCH; c++) hc[c] = 0;
        for (int k = 0; k < 256; k++) begin
            for (int c = 0; c < NCH; c++) if (pwm_o[c]) hc[c]++;
            @(negedge clk);
        end
        chk(hc[0] == 1,   "R10 ch0 high", hc[0], 1);
        chk(hc[1] == 51,  "R10 ch1 high", hc[1], 51);
        chk(hc[2] == 101, "R10 ch2 high", hc[2], 101);
        chk(hc[3] == 256, "R10 ch3 high", hc[3], 256);
        chk(pwm_o == 4'hF, "R10 second common rise", int'(pwm_o), 15);

        // R9 mid-period duty write waits for wrap
        wr('h50, ctl(0, 1'b0));
        wr('h00, 32'd10);
        wr('h50, ctl(0, 1'b1));
        hi = 0; hi2 = 0;
        for (int k = 0; k < 512; k++) begin
            if (pwm_o[0]) begin
                if (k < 256) hi++; else hi2++;
            end
            if (k == 50) begin wr_en = 1'b1; addr = 7'h00; wdata = 32'd200; end
            if (k == 51) wr_en = 1'b0;
            @(negedge clk);
        end
        chk(hi == 11,   "R9 current period unchanged", hi, 11);
        chk(hi2 == 201, "R9 new duty after wrap", hi2, 201);

        // R5 stop holds outputs low and restarts from zero
        wr('h50, ctl(0, 1'b0));
        wr('h00, 32'd100);
        wr('h50, ctl(0, 1'b1));
        repeat (5) @(negedge clk);
        wr('h50, ctl(0, 1'b0));
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            if (pwm_o != '0) hi++;
            @(negedge clk);
        end
        chk(hi == 0, "R5 outputs low while stopped", hi, 0);
        wr('h50, ctl(0, 1'b1));
        hi = 0;
        for (int k = 0; k < 256; k++) begin
            if (pwm_o[0]) hi++;
            @(negedge clk);
        end
        chk(hi == 101, "R5 restart from counter zero", hi, 101);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule